// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Generator

This block decodes a 20-bit bus address, together with a flag that tells memory cycles from I/O cycles, into a set of active-low chip selects. It can drive selects for four kinds of range. The first is a block that reaches up to the top of memory. The second is a block that starts at address zero. The third is a relocatable block of memory split into four equal quarters. The fourth is a row of seven 128-byte windows that sit in either memory space or I/O space. Five configuration registers hold the layout, and software loads them through a simple write port.

Each range also carries a wait-state count from 0 to 3 and a flag that says whether the external ready input is taken into account. When a bus cycle starts, the block loads the count of the range that matches. It holds its ready output low until the count has run out. After that it either asserts ready at once or waits for external ready as well. When no range matches, ready simply follows external ready. The two highest peripheral selects can instead carry address bits 1 and 2, captured at the start of the cycle, to feed the register-select pins of small peripherals.

Top module: `csgen_top`

## Requirements
- R1: While `rst` is high every select output is high. After reset the upper register holds 0xFFFB, so addresses 0xFFC00–0xFFFFF select `up_cs_n` with 3 wait states and external ready honoured.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register picked by `cfg_sel`: 0 upper, 1 lower, 2 mid base, 3 mid/peripheral config, 4 peripheral base. Other codes change nothing.
- R3: `up_cs_n` is low on a memory cycle (`is_io`=0) when addr[19:10] ≥ upper[15:6].
- R4: `lo_cs_n` stays high until the lower register has been written. After that it is low on a memory cycle when addr[19:10] ≤ lower[15:6].
- R5: The mid selects stay high until both the mid base and the config register have been written. Size code s = config[10:8], where codes above 6 act as 6, gives a block of 8 KB·2^s whose base is mid_base[15:9]·8 KB. On a memory cycle inside the block, `mid_cs_n[i]` is low for i = addr[12+s:11+s]. At most one of them is low.
- R6: The peripheral selects stay high until both the peripheral base and the config register have been written. After that, when the space matches (config[6]=1 memory, 0 I/O) and addr[19:10] = pbase[15:6], `per_cs_n[i]` is low for i = addr[9:7] < 7. At most one is low.
- R7: With config[7]=1, `per_cs_n[5]` and `per_cs_n[6]` output address bits 1 and 2 captured when `bus_start` is high, and windows 5 and 6 select nothing.
- R8: Bits [1:0] of the upper, lower, config (mid range) and peripheral-base registers hold each range's wait count N. After the clock edge that samples `bus_start`, `rdy` stays low for N cycles. When ranges overlap, the count is taken from upper, then lower, then mid, then peripheral, in that order.
- R9: Bit 2 of the same registers set to 1 ignores `ext_rdy`. Set to 0, `rdy` also needs `ext_rdy` high once the count has expired.
- R10: A cycle that matches no range gives `rdy` equal to `ext_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 16 | Register write data |
| addr | input | 20 | Bus address |
| is_io | input | 1 | 1 for an I/O cycle, 0 for memory |
| bus_start | input | 1 | One-cycle pulse at the start of a bus cycle |
| ext_rdy | input | 1 | External ready |
| up_cs_n | output | 1 | Upper memory select |
| lo_cs_n | output | 1 | Lower memory select |
| mid_cs_n | output | 4 | Mid-range memory selects |
| per_cs_n | output | 7 | Peripheral selects (5 and 6 may carry address bits) |
| rdy | output | 1 | Ready to the bus |

## Verification
The one-hot checks on the mid and peripheral selects assume that software aligns the mid base to the block size and keeps the ranges apart. For that reason the random configuration always places the upper block above 0xC0000, the lower block below 64 KB, the mid block in 0x40000–0x7FFFF with its base aligned, and the peripheral base in 0x20000–0x3FFFF. The wait-state assertions assume that `bus_start` is a single-cycle pulse, and the bench drives it that way and leaves it low while it counts wait cycles. Addresses are then drawn both inside and outside each range.

// File: rtl/csgen_pkg.sv
package csgen_pkg;
    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 16;
    localparam int BLK_LSB = 10;
    localparam int N_MID   = 4;
    localparam int N_PER   = 7;
    localparam int WIN_LSB = 7;
    localparam int MID_LSB = 13;
    localparam int WAIT_W  = 2;
    localparam int SEL_W   = 3;
    localparam logic [DATA_W-1:0] UP_RESET = 16'hFFFB;

    typedef enum logic [SEL_W-1:0] {
        SEL_UP   = 3'd0,
        SEL_LO   = 3'd1,
        SEL_MB   = 3'd2,
        SEL_MCFG = 3'd3,
        SEL_PB   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] up;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] mbase;
        logic [DATA_W-1:0] mcfg;
        logic [DATA_W-1:0] pbase;
    } cs_regs_t;

    typedef struct packed {
        logic              hit;
        logic              ign;
        logic [WAIT_W-1:0] n;
    } wait_cfg_t;

    function automatic wait_cfg_t wcfg_of(input logic [DATA_W-1:0] r);
        wait_cfg_t w;
        w.hit = 1'b1;
        w.ign = r[2];
        w.n   = r[WAIT_W-1:0];
        return w;
    endfunction

    function automatic logic [2:0] mid_size(input logic [DATA_W-1:0] cfg);
        return (cfg[10:8] > 3'd6) ? 3'd6 : cfg[10:8];
    endfunction
endpackage

// File: rtl/csgen_regs.sv
module csgen_regs
    import csgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output cs_regs_t          regs,
    output logic              lo_ok,
    output logic              mid_ok,
    output logic              per_ok
);
    logic lo_w, mb_w, mc_w, pb_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.up    <= UP_RESET;
            regs.lo    <= '0;
            regs.mbase <= '0;
            regs.mcfg  <= '0;
            regs.pbase <= '0;
            lo_w <= 1'b0;
            mb_w <= 1'b0;
            mc_w <= 1'b0;
            pb_w <= 1'b0;
        end else if (we) begin
            case (sel)
                SEL_UP:   regs.up <= wdata;
                SEL_LO:   begin regs.lo <= wdata;    lo_w <= 1'b1; end
                SEL_MB:   begin regs.mbase <= wdata; mb_w <= 1'b1; end
                SEL_MCFG: begin regs.mcfg <= wdata;  mc_w <= 1'b1; end
                SEL_PB:   begin regs.pbase <= wdata; pb_w <= 1'b1; end
                default:  ;
            endcase
        end
    end

    assign lo_ok  = lo_w;
    assign mid_ok = mb_w & mc_w;
    assign per_ok = pb_w & mc_w;

    // R1: upper register comes out of reset with its default value
    p_up_default_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (regs.up == UP_RESET));
    // R2: an unused select code leaves every register unchanged
    p_bad_sel_r2: assert property (@(posedge clk) disable iff (rst)
        (we && sel > 3'd4) |=> $stable(regs));
endmodule

// File: rtl/csgen_decode.sv
module csgen_decode
    import csgen_pkg::*;
#(
    parameter int NM = N_MID,
    parameter int NP = N_PER
) (
    input  logic              lo_ok,
    input  logic              mid_ok,
    input  logic              per_ok,
    input  cs_regs_t          regs,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    output logic              up_hit,
    output logic              lo_hit,
    output logic [NM-1:0]     mid_hit,
    output logic [NP-1:0]     per_hit,
    output wait_cfg_t         wcfg
);
    localparam int BLK_W = ADDR_W - BLK_LSB;
    localparam int MB_W  = ADDR_W - MID_LSB;

    logic [BLK_W-1:0]  blk;
    logic [2:0]        sz;
    logic [4:0]        sh;
    logic [ADDR_W-1:0] mid_base;
    logic              mid_in;
    logic [1:0]        quarter;
    logic              per_in;
    logic [2:0]        win;
    logic              amode;

    assign blk      = addr[ADDR_W-1:BLK_LSB];
    assign sz       = mid_size(regs.mcfg);
    assign sh       = 5'(MID_LSB) + {2'b00, sz};
    assign mid_base = {regs.mbase[DATA_W-1 -: MB_W], {MID_LSB{1'b0}}};
    assign amode    = regs.mcfg[7];
    assign win      = addr[WIN_LSB +: 3];

    always_comb begin
        up_hit  = !is_io && (blk >= regs.up[DATA_W-1 -: BLK_W]);
        lo_hit  = lo_ok && !is_io && (blk <= regs.lo[DATA_W-1 -: BLK_W]);
        mid_in  = mid_ok && !is_io && (((addr ^ mid_base) >> sh) == '0);
        quarter = 2'(addr >> (sh - 5'd2));
        per_in  = per_ok && (is_io == !regs.mcfg[6]) &&
                  (blk == regs.pbase[DATA_W-1 -: BLK_W]);
    end

    for (genvar i = 0; i < NM; i++) begin : g_mid
        assign mid_hit[i] = mid_in && (quarter == 2'(i));
    end

    for (genvar i = 0; i < NP; i++) begin : g_per
        if (i >= 5) begin : g_shared
            assign per_hit[i] = per_in && !amode && (win == 3'(i));
        end else begin : g_plain
            assign per_hit[i] = per_in && (win == 3'(i));
        end
    end

    always_comb begin
        wcfg = '0;
        if (up_hit)          wcfg = wcfg_of(regs.up);
        else if (lo_hit)     wcfg = wcfg_of(regs.lo);
        else if (|mid_hit)   wcfg = wcfg_of(regs.mcfg);
        else if (|per_hit)   wcfg = wcfg_of(regs.pbase);
    end
endmodule

// File: rtl/csgen_wait.sv
module csgen_wait
    import csgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  wait_cfg_t wcfg,
    input  logic      ext_rdy,
    output logic      rdy
);
    logic [WAIT_W-1:0] cnt;
    logic              hit_q;
    logic              ign_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            hit_q <= 1'b0;
            ign_q <= 1'b0;
        end else if (start) begin
            cnt   <= wcfg.n;
            hit_q <= wcfg.hit;
            ign_q <= wcfg.ign;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign rdy = hit_q ? ((cnt == '0) && (ign_q || ext_rdy)) : ext_rdy;

    // R8: a nonzero count holds ready low in the cycle after the start
    p_wait_low_r8: assert property (@(posedge clk) disable iff (rst)
        (start && wcfg.hit && wcfg.n != '0) |=> !rdy);
    // R9: zero waits with external ready ignored gives ready at once
    p_ignore_ext_r9: assert property (@(posedge clk) disable iff (rst)
        (start && wcfg.hit && wcfg.ign && wcfg.n == '0) |=> rdy);
    // R10: an unmatched cycle passes external ready straight through
    p_nomatch_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !wcfg.hit) |=> (rdy == ext_rdy));
endmodule

// File: rtl/csgen_top.sv
module csgen_top
    import csgen_pkg::*;
#(
    parameter int NM = N_MID,
    parameter int NP = N_PER
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    input  logic              bus_start,
    input  logic              ext_rdy,
    output logic              up_cs_n,
    output logic              lo_cs_n,
    output logic [NM-1:0]     mid_cs_n,
    output logic [NP-1:0]     per_cs_n,
    output logic              rdy
);
    cs_regs_t  regs;
    logic      lo_ok, mid_ok, per_ok;
    logic      up_hit, lo_hit;
    logic [NM-1:0] mid_hit;
    logic [NP-1:0] per_hit;
    wait_cfg_t wcfg;
    logic [1:0] a_lat;
    logic       amode;

    csgen_regs i_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .regs(regs), .lo_ok(lo_ok), .mid_ok(mid_ok), .per_ok(per_ok)
    );

    csgen_decode #(.NM(NM), .NP(NP)) i_dec (
        .lo_ok(lo_ok), .mid_ok(mid_ok), .per_ok(per_ok), .regs(regs),
        .addr(addr), .is_io(is_io), .up_hit(up_hit), .lo_hit(lo_hit),
        .mid_hit(mid_hit), .per_hit(per_hit), .wcfg(wcfg)
    );

    csgen_wait i_wait (
        .clk(clk), .rst(rst), .start(bus_start), .wcfg(wcfg),
        .ext_rdy(ext_rdy), .rdy(rdy)
    );

    always_ff @(posedge clk) begin
        if (rst)            a_lat <= '0;
        else if (bus_start) a_lat <= {addr[2], addr[1]};
    end

    assign amode = regs.mcfg[7];

    always_comb begin
        up_cs_n  = rst | ~up_hit;
        lo_cs_n  = rst | ~lo_hit;
        mid_cs_n = {NM{rst}} | ~mid_hit;
        per_cs_n = {NP{rst}} | ~per_hit;
        if (!rst && amode && NP > 6) begin
            per_cs_n[5] = a_lat[0];
            per_cs_n[6] = a_lat[1];
        end
    end

    // R1: every select is inactive during reset
    p_rst_idle_r1: assert property (@(posedge clk)
        rst |-> (up_cs_n && lo_cs_n && &mid_cs_n && &per_cs_n));
    // R4: lower select stays off until its register is written
    p_lo_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !lo_ok |-> lo_cs_n);
    // R5: at most one mid-range select at a time
    p_mid_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mid_cs_n));
    // R6: peripheral selects are one-hot and gated until configured
    p_per_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        !amode |-> $onehot0(~per_cs_n));
    p_per_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (!per_ok && !amode) |-> &per_cs_n);
endmodule

// File: tb/test_csgen_top.sv
module test_csgen_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [19:0] addr = '0;
    logic        is_io = 1'b0;
    logic        bus_start = 1'b0;
    logic        ext_rdy = 1'b1;
    logic        up_cs_n, lo_cs_n, rdy;
    logic [3:0]  mid_cs_n;
    logic [6:0]  per_cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the configuration
    logic [15:0] m_up = 16'hFFFB, m_lo = '0, m_mb = '0, m_mc = '0, m_pb = '0;
    bit w_lo = 0, w_mb = 0, w_mc = 0, w_pb = 0;

    csgen_top i_csgen_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .addr(addr), .is_io(is_io),
        .bus_start(bus_start), .ext_rdy(ext_rdy), .up_cs_n(up_cs_n),
        .lo_cs_n(lo_cs_n), .mid_cs_n(mid_cs_n), .per_cs_n(per_cs_n), .rdy(rdy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (s)
            3'd0: m_up = d;
            3'd1: begin m_lo = d; w_lo = 1; end
            3'd2: begin m_mb = d; w_mb = 1; end
            3'd3: begin m_mc = d; w_mc = 1; end
            3'd4: begin m_pb = d; w_pb = 1; end
            default: ;
        endcase
    endtask

    function automatic int msz();
        return (m_mc[10:8] > 3'd6) ? 6 : int'(m_mc[10:8]);
    endfunction

    // hit vector {per[6:0], mid[3:0], lo, up}, active high
    function automatic logic [12:0] hits(input logic [19:0] a, input logic io);
        logic [12:0] h = '0;
        int s, w;
        logic [19:0] base;
        h[0] = !io && (a[19:10] >= m_up[15:6]);
        h[1] = w_lo && !io && (a[19:10] <= m_lo[15:6]);
        s = msz();
        base = {m_mb[15:9], 13'b0};
        if (w_mb && w_mc && !io && ((a >> (13 + s)) == (base >> (13 + s))))
            h[2 + ((a >> (11 + s)) & 3)] = 1'b1;
        w = int'(a[9:7]);
        if (w_pb && w_mc && (io == !m_mc[6]) && a[19:10] == m_pb[15:6] && w < 7
            && !(m_mc[7] && w >= 5))
            h[6 + w] = 1'b1;
        return h;
    endfunction

    function automatic logic [12:0] exp_sel(input logic [19:0] a, input logic io);
        logic [12:0] e = ~hits(a, io);
        if (m_mc[7]) begin
            e[11] = a[1];
            e[12] = a[2];
        end
        return e;
    endfunction

    function automatic logic exp_rdy(input logic [19:0] a, input logic io,
                                     input logic ext, input int j);
        logic [12:0] h = hits(a, io);
        logic [15:0] r;
        if (h[0])            r = m_up;
        else if (h[1])       r = m_lo;
        else if (|h[5:2])    r = m_mc;
        else if (|h[12:6])   r = m_pb;
        else return ext;
        return (j >= int'(r[1:0])) && (r[2] || ext);
    endfunction

    function automatic logic [12:0] act_sel();
        return {per_cs_n, mid_cs_n, lo_cs_n, up_cs_n};
    endfunction

    // one bus cycle; checks selects and ready for cycles 0..nr
    task automatic access(input logic [19:0] a, input logic io, input logic ext,
                          input int nr, input string req);
        @(negedge clk);
        addr = a; is_io = io; ext_rdy = ext; bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
        check({req, " sel"}, 32'(act_sel()), 32'(exp_sel(a, io)));
        for (int j = 0; j <= nr; j++) begin
            if (j > 0) @(negedge clk);
            check({req, " rdy"}, 32'(rdy), 32'(exp_rdy(a, io, ext, j)));
        end
    endtask

    initial begin
        // R1: outputs idle during reset
        addr = 20'hFFC10;
        repeat (3) @(negedge clk);
        check("R1 reset idle", 32'(act_sel()), 32'h1FFF);
        rst = 1'b0;
        // R1/R3/R8/R9: default upper block, 3 waits, external ready used
        access(20'hFFC00, 1'b0, 1'b1, 4, "R1 R8 up default");
        access(20'hFFFFF, 1'b0, 1'b0, 4, "R9 up ext low");
        access(20'hFFBFF, 1'b0, 1'b1, 1, "R3 R10 below up");
        // R4: lower unwritten is inactive
        access(20'h00000, 1'b0, 1'b1, 0, "R4 lo gated");
        wr(3'd1, {10'h003, 3'b111, 1'b1, 2'd2});
        access(20'h00FFF, 1'b0, 1'b0, 3, "R4 R9 lo top ignore ext");
        access(20'h01000, 1'b0, 1'b1, 0, "R4 lo above limit");
        // R2: unused select code changes nothing
        wr(3'd6, 16'h0000);
        access(20'h00100, 1'b0, 1'b1, 0, "R2 bad sel");
        // R6: peripheral base alone keeps selects off
        wr(3'd4, {10'h090, 3'b000, 1'b0, 2'd1});
        access(20'h24000, 1'b0, 1'b1, 0, "R6 per gated");
        // R5: mid base alone keeps selects off
        wr(3'd2, {7'h20, 9'h0});
        access(20'h40000, 1'b0, 1'b1, 0, "R5 mid gated");
        // config: size code 7 (acts as 6), memory peripherals
        wr(3'd3, {5'b0, 3'd7, 1'b0, 1'b1, 3'b000, 1'b1, 2'd0});
        access(20'h7FFFF, 1'b0, 1'b1, 1, "R5 mid size clamp");
        access(20'h40000, 1'b0, 1'b0, 1, "R5 R9 mid q0");
        access(20'h24300, 1'b0, 1'b1, 2, "R6 per win6");
        access(20'h24380, 1'b0, 1'b1, 0, "R6 per win7");
        access(20'h24000, 1'b1, 1'b1, 0, "R6 per space");
        // R7: address mode
        wr(3'd3, {5'b0, 3'd0, 1'b1, 1'b1, 3'b000, 1'b0, 2'd3});
        access(20'h24286, 1'b0, 1'b1, 0, "R7 amode win5");
        access(20'h24302, 1'b0, 1'b1, 0, "R7 amode win6");
        access(20'h24080, 1'b0, 1'b1, 2, "R7 R8 amode win1");

        // constrained random
        void'($urandom(32'd1234));
        for (int k = 0; k < 400; k++) begin
            if (k % 50 == 0) begin
                logic [2:0] sz = 3'($urandom % 5);
                logic [6:0] mb = {2'b01, 5'($urandom)} & ~7'((1 << sz) - 1);
                wr(3'd0, {10'h300 | 10'($urandom % 256), 3'b111, 3'($urandom)});
                wr(3'd1, {10'($urandom % 64), 3'b111, 3'($urandom)});
                wr(3'd2, {mb, 9'h0});
                wr(3'd3, {5'b0, sz, 1'($urandom), 1'($urandom), 3'b000, 3'($urandom)});
                wr(3'd4, {10'h080 | 10'($urandom % 128), 3'b000, 3'($urandom)});
            end
            begin
                logic [19:0] a;
                logic io = ($urandom % 4 == 0);
                case ($urandom % 5)
                    0: a = 20'hC0000 | 20'($urandom % 20'h40000);
                    1: a = 20'($urandom % 20'h10000);
                    2: a = 20'h40000 | 20'($urandom % 20'h40000);
                    3: a = {m_pb[15:6], 10'($urandom)};
                    default: a = 20'($urandom);
                endcase
                access(a, io, 1'($urandom), 0, "R3 R4 R5 R6 R8 R10 random");
            end
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule